// File: doc/BRIEF.md
# Strobe-Timed Four-Word Receive Deserializer

This block gathers words arriving on a source-synchronous receive path where the sender marks each new word by toggling a reference strobe rather than by supplying a clock. Every transition of the strobe, rising or falling, stands for one new data word. The block collects four such words in a row into a group and presents them side by side as one wide parallel word. A one-cycle valid pulse marks each completed group.

The block runs on a fast local clock. Both strobe inputs and the data input pass through the same number of synchronizing register stages, so data and strobe stay aligned. A strobe transition is found by comparing the synchronized strobe with its value one clock earlier. A polarity flip-flop and a divide-by-2 flip-flop together name the phase of the next word and steer it into one of four holding slots.

While the receive enable is low, both flip-flops are held cleared. The first transition after the enable rises therefore always fills slot 0, whatever level the strobe rests at. A mode input selects which of two channel strobes paces the capture. The selection is expected to change only while the receive enable is low.

Top module: `strq_deser4`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `word_vld` is 0 and `word_out` is all zeros.
- R2: While `rx_en` is high, each change in level of the selected strobe captures exactly one word, on either a rising or a falling change. The change is first sampled at clock edge t and is acted on at edge t+SYNC_STAGES.
- R3: The first word of a group appears in `word_out[DATA_W-1:0]`, the second in the next DATA_W bits up, and the fourth in `word_out[4*DATA_W-1:3*DATA_W]`.
- R4: `word_vld` is high for exactly one cycle per completed group, starting after the edge that captures the fourth word. `word_out` holds its value at all other times.
- R5: The first strobe transition after `rx_en` rises fills slot 0, whether the strobe rests high or low.
- R6: Lowering `rx_en` discards a partially filled group. The next group starts again at slot 0.
- R7: `chan_sel`=0 selects `strb_a` and `chan_sel`=1 selects `strb_b`. Transitions on the strobe that is not selected have no effect.
- R8: The captured word is the value of `din` sampled at the same clock edge as the strobe change, even if `din` changes one cycle later.
- R9: Strobe transitions while `rx_en` is low capture nothing and raise no `word_vld`.
- R10: Strobe transitions on consecutive clock cycles are each captured as separate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; while low, holds the slot phase at 0 |
| chan_sel | input | 1 | Strobe select: 0 selects strb_a, 1 selects strb_b |
| strb_a | input | 1 | Toggling strobe of channel A |
| strb_b | input | 1 | Toggling strobe of channel B |
| din | input | DATA_W (18) | Incoming data word |
| word_out | output | 4*DATA_W (72) | Parallel group of four words, first word in the low bits |
| word_vld | output | 1 | One-cycle pulse when word_out is updated |

## Verification
The bench starts groups with the strobe resting both low and high. A design that decoded phase from the absolute strobe level, instead of from transitions counted since enable, would then put the first word into slot 1 or 2. It drops the enable in the middle of a group and toggles the strobe while disabled. A design that kept stale slot state would raise the valid pulse early, or fill the group with mixed words. It toggles the strobe on back-to-back cycles, and it changes data one cycle after the strobe. A mismatch between the data and strobe pipeline depths, or a missed second edge, shows up as shifted or lost words. It also toggles the strobe that is not selected. A design that decoded the mode backwards would then capture from the wrong channel.

// File: rtl/strq_pkg.sv
package strq_pkg;
  localparam int LANES = 4;
  localparam int PH_W  = 2;
  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/strq_sync.sv
module strq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/strq_phase.sv
module strq_phase
  import strq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             evt,
  output phase_t           phase,
  output logic [LANES-1:0] lane_en
);
  logic pol_q;  // toggles on every transition
  logic div_q;  // divide-by-2: toggles on every second transition

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      pol_q <= 1'b0;
      div_q <= 1'b0;
    end else if (evt) begin
      pol_q <= ~pol_q;
      if (pol_q) div_q <= ~div_q;
    end
  end

  assign phase = {div_q, pol_q};

  for (genvar k = 0; k < LANES; k++) begin : g_en
    localparam phase_t KP = phase_t'(k);
    assign lane_en[k] = rx_en & evt & (pol_q == KP[0]) & (div_q == KP[1]);
  end

  // R6: disable returns the phase to slot 0
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (phase == '0));
  // R2: each enabled transition advances exactly one slot
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (rx_en && evt) |=> (phase == phase_t'($past(phase) + 1'b1)));
  // R9: no transition, no movement
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_en && !evt) |=> $stable(phase));
  // R3: at most one slot written per cycle
  a_r3_one_slot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_en));
endmodule

// File: rtl/strq_lanes.sv
module strq_lanes
  import strq_pkg::*;
#(
  parameter int W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES-1:0]   lane_en,
  input  logic [W-1:0]       din,
  output logic [LANES*W-1:0] word_out,
  output logic               word_vld
);
  logic [W-1:0] slot_q [LANES-1];

  for (genvar k = 0; k < LANES-1; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)             slot_q[k] <= '0;
      else if (lane_en[k]) slot_q[k] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= lane_en[LANES-1];
      if (lane_en[LANES-1]) begin
        for (int k = 0; k < LANES-1; k++) word_out[k*W +: W] <= slot_q[k];
        word_out[(LANES-1)*W +: W] <= din;
      end
    end
  end

  // R4: valid never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
  // R4: the parallel word moves only with valid
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_out));
endmodule

// File: rtl/strq_deser4.sv
module strq_deser4
  import strq_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_en,
  input  logic                  chan_sel,
  input  logic                  strb_a,
  input  logic                  strb_b,
  input  logic [DATA_W-1:0]     din,
  output logic [LANES*DATA_W-1:0] word_out,
  output logic                  word_vld
);
  logic [1:0]        strb_s;
  logic [DATA_W-1:0] din_s;
  logic              strb_cur, strb_prev, evt;
  phase_t            phase;
  logic [LANES-1:0]  lane_en;

  strq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ssync (
    .clk(clk), .rst(rst), .d({strb_b, strb_a}), .q(strb_s));

  strq_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_dsync (
    .clk(clk), .rst(rst), .d(din), .q(din_s));

  assign strb_cur = chan_sel ? strb_s[1] : strb_s[0];

  always_ff @(posedge clk) begin
    if (rst) strb_prev <= 1'b0;
    else     strb_prev <= strb_cur;
  end

  assign evt = strb_cur ^ strb_prev;

  strq_phase u_phase (
    .clk(clk), .rst(rst), .rx_en(rx_en), .evt(evt),
    .phase(phase), .lane_en(lane_en));

  strq_lanes #(.W(DATA_W)) u_lanes (
    .clk(clk), .rst(rst), .lane_en(lane_en), .din(din_s),
    .word_out(word_out), .word_vld(word_vld));

  // R4/R2: valid follows only an enabled transition in the last slot
  a_r4_vld_source: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(rx_en && evt && (phase == phase_t'(LANES-1))));
  // R1: reset leaves no valid
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !word_vld);
endmodule

// File: tb/sim_strq_deser4.sv
module sim_strq_deser4;
  localparam int W = 18;
  localparam int L = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, rx_en = 1'b0, chan_sel = 1'b0;
  logic strb_a = 1'b0, strb_b = 1'b0;
  logic [W-1:0] din = '0;
  logic [4*W-1:0] word_out;
  logic word_vld;

  strq_deser4 #(.DATA_W(W), .SYNC_STAGES(L)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .chan_sel(chan_sel),
    .strb_a(strb_a), .strb_b(strb_b), .din(din),
    .word_out(word_out), .word_vld(word_vld));

  // behavioural reference
  logic qa[$], qb[$];
  logic [W-1:0] qd[$];
  int cnt;
  logic [W-1:0] held [4];
  logic [4*W-1:0] exp_out;
  logic exp_vld;
  string tag = "R1";
  int checks = 0, errors = 0, vld_seen = 0;

  task automatic model_clear();
    qa = {}; qb = {}; qd = {};
    for (int i = 0; i <= L; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); qd.push_back('0); end
    cnt = 0; exp_out = '0; exp_vld = 1'b0;
  endtask

  task automatic model_step();
    logic c, p;
    if (rst) begin
      model_clear();
      return;
    end
    c = chan_sel ? qb[L-1] : qa[L-1];
    p = chan_sel ? qb[L]   : qa[L];
    exp_vld = 1'b0;
    if (!rx_en) cnt = 0;
    else if (c != p) begin
      held[cnt] = qd[L-1];
      if (cnt == 3) begin
        exp_out = {held[3], held[2], held[1], held[0]};
        exp_vld = 1'b1;
      end
      cnt = (cnt + 1) % 4;
    end
    qa.push_front(strb_a); void'(qa.pop_back());
    qb.push_front(strb_b); void'(qb.pop_back());
    qd.push_front(din);    void'(qd.pop_back());
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    if (word_vld) vld_seen++;
    checks++;
    if (word_out !== exp_out || word_vld !== exp_vld) begin
      errors++;
      $display("FAIL %s out=%h/vld=%b expected %h/vld=%b", tag, word_out, word_vld, exp_out, exp_vld);
    end
  endtask

  task automatic chk(string req, logic [4*W-1:0] act, logic [4*W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic xfer(logic [W-1:0] d, int hold, bit garble);
    if (chan_sel) strb_b = ~strb_b; else strb_a = ~strb_a;
    din = d;
    tick();
    if (garble) din = ~d;
    for (int i = 1; i < hold; i++) tick();
  endtask

  task automatic group(logic [W-1:0] b, int hold, bit garble);
    for (int k = 0; k < 4; k++) xfer(b + W'(k), hold, garble);
    for (int i = 0; i < L + 2; i++) tick();
  endtask

  function automatic logic [4*W-1:0] pack(logic [W-1:0] b);
    return {b + W'(3), b + W'(2), b + W'(1), b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    for (int i = 0; i < 3; i++) tick();
    tag = "R1";
    chk("R1", {word_out, 71'd0} >> 71, {72'd0});
    chk("R1", word_out, '0);
    rst = 1'b0;
    tick();

    // R5/R2/R3: strobe resting low, slow words
    tag = "R5_R3"; rx_en = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    vld_seen = 0;
    group(18'h01000, 4, 1'b0);
    chk("R3", word_out, pack(18'h01000));
    chk("R4", 72'(vld_seen), 72'd1);

    // R10: back-to-back transitions, two groups
    tag = "R10"; vld_seen = 0;
    for (int k = 0; k < 8; k++) xfer(18'h22000 + W'(k), 1, 1'b0);
    for (int i = 0; i < L + 2; i++) tick();
    chk("R10", word_out, pack(18'h22004));
    chk("R10", 72'(vld_seen), 72'd2);

    // R6: partial group dropped on disable
    tag = "R6"; vld_seen = 0;
    xfer(18'h3AAAA, 3, 1'b0);
    xfer(18'h3BBBB, 3, 1'b0);
    for (int i = 0; i < L + 1; i++) tick();
    rx_en = 1'b0; for (int i = 0; i < 3; i++) tick();
    rx_en = 1'b1; for (int i = 0; i < 3; i++) tick();
    group(18'h04400, 3, 1'b0);
    chk("R6", word_out, pack(18'h04400));
    chk("R6", 72'(vld_seen), 72'd1);

    // R9: toggles while disabled ignored; then R5 with strobe resting high
    tag = "R9"; vld_seen = 0;
    rx_en = 1'b0; tick();
    for (int k = 0; k < 5; k++) xfer(18'h15550 + W'(k), 2, 1'b0);
    for (int i = 0; i < L + 2; i++) tick();
    chk("R9", 72'(vld_seen), 72'd0);
    chk("R9", word_out, pack(18'h04400));
    tag = "R5"; rx_en = 1'b1; for (int i = 0; i < 3; i++) tick();
    group(18'h05500, 3, 1'b0);
    chk("R5", word_out, pack(18'h05500));

    // R7: channel B selected, channel A toggles are noise
    tag = "R7"; rx_en = 1'b0; chan_sel = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    rx_en = 1'b1; for (int i = 0; i < 3; i++) tick();
    vld_seen = 0;
    for (int k = 0; k < 4; k++) begin
      xfer(18'h07700 + W'(k), 2, 1'b0);
      strb_a = ~strb_a; din = 18'h3FFFF; tick(); tick();
    end
    for (int i = 0; i < L + 2; i++) tick();
    chk("R7", word_out, pack(18'h07700));
    chk("R7", 72'(vld_seen), 72'd1);

    // R8: data changes one cycle after the strobe
    tag = "R8"; vld_seen = 0;
    group(18'h08800, 3, 1'b1);
    chk("R8", word_out, pack(18'h08800));
    chk("R8", 72'(vld_seen), 72'd1);

    // R1: reset in mid-run clears outputs
    tag = "R1"; rst = 1'b1; tick(); tick();
    chk("R1", word_out, '0);
    rst = 1'b0; tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule